// File: doc/BRIEF.md
# Clock Setting Register Bank with Key Lock

This block stores the settings that steer a clock management unit: the PLL multiplier, the output divider, the VCO band, the loop-filter resistance, the PLL enable, the spread-spectrum enable, and the spread-spectrum interval and deviation. Software reaches it over a small synchronous byte bus with an address, write data, a write strobe, a read strobe and registered read data. Every stored field also drives its own output wire toward the clock logic.

All setting registers in the offset window 0x100 to 0x10D are guarded by a key register at offset 0x110. Writing the single key byte 0x96 there opens the bank. Writing any other byte there closes it. While the bank is closed, writes to guarded registers are dropped without notice. Reads work at all times.

The PLL status byte is fixed. Reserved bits read as zero. An illegal divider code is refused.

Top module: `clkcfg_regbank`

## Requirements
- R1: After reset the outputs are mult 0, vdiv 1, pll_en 0, vco_band 1, lpf_res 8, ss_en 0, ss_interval 0 and ss_dev 0, and the bank is closed.
- R2: Writing 0x96 to offset 0x110 opens the bank, and the key register then reads 0x01.
- R3: Writing any byte other than 0x96 to offset 0x110 closes the bank, and the key register then reads 0x00.
- R4: While the bank is closed, a write to any offset from 0x100 to 0x10D changes no stored field.
- R5: Offset 0x108 holds mult in bits 7:4, vdiv in bits 3:2 and pll_en in bit 0. Bit 1 always reads 0.
- R6: A write of vdiv code 0 is refused and the old vdiv is kept, while the other fields of that same write are still taken.
- R7: Offset 0x109 holds vco_band in bits 7:4 and lpf_res in bits 3:0.
- R8: Offset 0x10A always reads 0x10: capacitance 0 in bits 7:6, bypass 0 in bit 5 and charge pump 0x10 in bits 4:0. Writes to it change nothing.
- R9: Offset 0x10C holds ss_en in bit 0, and its bits 7:1 read 0.
- R10: Offset 0x10D holds ss_interval in bits 7:4 and ss_dev in bits 3:0.
- R11: Reads of unmapped offsets return 0x00. Writes to unmapped offsets have no effect. Reads work whether the bank is open or closed.
- R12: rdata is valid in the cycle after rd_en. When a read and a write fall in the same cycle, rdata returns the value from before that write. rdata holds its value while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr | input | ADDR_W | Byte offset on the bus |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| pll_mult | output | 4 | Multiplier code; code n multiplies by n+1 |
| pll_vdiv | output | 2 | Output divider code, never 0 |
| pll_en | output | 1 | PLL enable |
| vco_band | output | 4 | VCO band selection |
| lpf_res | output | 4 | Loop-filter resistance selection |
| ss_en | output | 1 | Spread-spectrum enable |
| ss_interval | output | 4 | Spread-spectrum interval |
| ss_dev | output | 4 | Spread-spectrum deviation width |

## Verification
A read and a write can hit the same register in the same cycle. The bench provokes this by raising both strobes together on offset 0x109. It expects rdata to return the value from before the write, and expects the next read to return the new value. A second collision involves the key. A relock write is followed straight away by a guarded write, and the bench checks at the field outputs that the lock closed in time to drop the guarded write.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int FIELD_W   = 4;
  localparam int DATA_W    = 8;
  localparam int OFS_LO    = 'h100;
  localparam int OFS_HI    = 'h10D;
  localparam int OFS_CTL0  = 'h108;
  localparam int OFS_CTL1  = 'h109;
  localparam int OFS_STAT  = 'h10A;
  localparam int OFS_SSEN  = 'h10C;
  localparam int OFS_SSCFG = 'h10D;
  localparam int OFS_KEY   = 'h110;
  localparam logic [1:0]        RST_VDIV = 2'd1;
  localparam logic [FIELD_W-1:0] RST_VCO = 4'h1;
  localparam logic [FIELD_W-1:0] RST_LPF = 4'h8;
  localparam logic [DATA_W-1:0] STAT_VAL = {2'b00, 1'b0, 5'h10};
endpackage

// File: rtl/clkcfg_rstsync.sv
module clkcfg_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/clkcfg_unlock.sv
module clkcfg_unlock #(
  parameter logic [7:0] KEY = 8'h96
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_we,
  input  logic [7:0] wdata,
  output logic       open_q
);
  logic open_d;

  always_comb begin
    open_d = open_q;
    if (key_we) open_d = (wdata == KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= open_d;
  end
endmodule

// File: rtl/clkcfg_fields.sv
module clkcfg_fields
  import clkcfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_ctl0,
  input  logic               we_ctl1,
  input  logic               we_ssen,
  input  logic               we_sscfg,
  input  logic [DATA_W-1:0]  wdata,
  output logic [FIELD_W-1:0] mult_q,
  output logic [1:0]         vdiv_q,
  output logic               en_q,
  output logic [FIELD_W-1:0] vco_q,
  output logic [FIELD_W-1:0] lpf_q,
  output logic               ssen_q,
  output logic [FIELD_W-1:0] ssint_q,
  output logic [FIELD_W-1:0] ssdev_q
);
  logic [FIELD_W-1:0] mult_d, vco_d, lpf_d, ssint_d, ssdev_d;
  logic [1:0]         vdiv_d;
  logic               en_d, ssen_d;

  always_comb begin
    mult_d  = mult_q;
    vdiv_d  = vdiv_q;
    en_d    = en_q;
    vco_d   = vco_q;
    lpf_d   = lpf_q;
    ssen_d  = ssen_q;
    ssint_d = ssint_q;
    ssdev_d = ssdev_q;
    if (we_ctl0) begin
      mult_d = wdata[7:4];
      en_d   = wdata[0];
      if (wdata[3:2] != 2'd0) vdiv_d = wdata[3:2];
    end
    if (we_ctl1) begin
      vco_d = wdata[7:4];
      lpf_d = wdata[3:0];
    end
    if (we_ssen) ssen_d = wdata[0];
    if (we_sscfg) begin
      ssint_d = wdata[7:4];
      ssdev_d = wdata[3:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mult_q  <= '0;
      vdiv_q  <= RST_VDIV;
      en_q    <= 1'b0;
      vco_q   <= RST_VCO;
      lpf_q   <= RST_LPF;
      ssen_q  <= 1'b0;
      ssint_q <= '0;
      ssdev_q <= '0;
    end else begin
      mult_q  <= mult_d;
      vdiv_q  <= vdiv_d;
      en_q    <= en_d;
      vco_q   <= vco_d;
      lpf_q   <= lpf_d;
      ssen_q  <= ssen_d;
      ssint_q <= ssint_d;
      ssdev_q <= ssdev_d;
    end
  end
endmodule

// File: rtl/clkcfg_rdmux.sv
module clkcfg_rdmux
  import clkcfg_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               bank_open,
  input  logic [FIELD_W-1:0] mult,
  input  logic [1:0]         vdiv,
  input  logic               en,
  input  logic [FIELD_W-1:0] vco,
  input  logic [FIELD_W-1:0] lpf,
  input  logic               ssen,
  input  logic [FIELD_W-1:0] ssint,
  input  logic [FIELD_W-1:0] ssdev,
  output logic [DATA_W-1:0]  rdata_q
);
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    case (addr)
      ADDR_W'(OFS_CTL0):  rd_d = {mult, vdiv, 1'b0, en};
      ADDR_W'(OFS_CTL1):  rd_d = {vco, lpf};
      ADDR_W'(OFS_STAT):  rd_d = STAT_VAL;
      ADDR_W'(OFS_SSEN):  rd_d = {{(DATA_W-1){1'b0}}, ssen};
      ADDR_W'(OFS_SSCFG): rd_d = {ssint, ssdev};
      ADDR_W'(OFS_KEY):   rd_d = {{(DATA_W-1){1'b0}}, bank_open};
      default:            rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_d;
  end
endmodule

// File: rtl/clkcfg_regbank.sv
module clkcfg_regbank
  import clkcfg_pkg::*;
#(
  parameter int         ADDR_W      = 9,
  parameter logic [7:0] KEY         = 8'h96,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               wr_en,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rdata,
  output logic [FIELD_W-1:0] pll_mult,
  output logic [1:0]         pll_vdiv,
  output logic               pll_en,
  output logic [FIELD_W-1:0] vco_band,
  output logic [FIELD_W-1:0] lpf_res,
  output logic               ss_en,
  output logic [FIELD_W-1:0] ss_interval,
  output logic [FIELD_W-1:0] ss_dev
);
  logic rst_q;
  logic bank_open;
  logic in_bank, wr_ok, key_we;

  clkcfg_rstsync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  always_comb begin
    in_bank = (addr >= ADDR_W'(OFS_LO)) && (addr <= ADDR_W'(OFS_HI));
    wr_ok   = wr_en && in_bank && bank_open;
    key_we  = wr_en && (addr == ADDR_W'(OFS_KEY));
  end

  clkcfg_unlock #(.KEY(KEY)) u_key (
    .clk(clk), .rst_n(rst_q), .key_we(key_we), .wdata(wdata), .open_q(bank_open)
  );

  clkcfg_fields u_fld (
    .clk      (clk),
    .rst_n    (rst_q),
    .we_ctl0  (wr_ok && (addr == ADDR_W'(OFS_CTL0))),
    .we_ctl1  (wr_ok && (addr == ADDR_W'(OFS_CTL1))),
    .we_ssen  (wr_ok && (addr == ADDR_W'(OFS_SSEN))),
    .we_sscfg (wr_ok && (addr == ADDR_W'(OFS_SSCFG))),
    .wdata    (wdata),
    .mult_q   (pll_mult),
    .vdiv_q   (pll_vdiv),
    .en_q     (pll_en),
    .vco_q    (vco_band),
    .lpf_q    (lpf_res),
    .ssen_q   (ss_en),
    .ssint_q  (ss_interval),
    .ssdev_q  (ss_dev)
  );

  clkcfg_rdmux #(.ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst_n(rst_q), .rd_en(rd_en), .addr(addr), .bank_open(bank_open),
    .mult(pll_mult), .vdiv(pll_vdiv), .en(pll_en), .vco(vco_band), .lpf(lpf_res),
    .ssen(ss_en), .ssint(ss_interval), .ssdev(ss_dev), .rdata_q(rdata)
  );
endmodule

// File: rtl/clkcfg_regbank_chk.sv
module clkcfg_regbank_chk #(
  parameter int         ADDR_W = 9,
  parameter logic [7:0] KEY    = 8'h96
) (
  input logic              clk,
  input logic              rst_q,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        rdata,
  input logic [3:0]        pll_mult,
  input logic [1:0]        pll_vdiv,
  input logic              pll_en,
  input logic              bank_open
);
  p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && addr == ADDR_W'('h110) && wdata == KEY) |=> bank_open);

  p_relock_r3: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && addr == ADDR_W'('h110) && wdata != KEY) |=> !bank_open);

  p_locked_drop_r4: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && !bank_open && addr == ADDR_W'('h108))
      |=> ($stable(pll_mult) && $stable(pll_vdiv) && $stable(pll_en)));

  p_vdiv_legal_r6: assert property (@(posedge clk) disable iff (!rst_q)
    (wr_en && addr == ADDR_W'('h108) && wdata[3:2] == 2'd0) |=> $stable(pll_vdiv));

  p_status_fixed_r8: assert property (@(posedge clk) disable iff (!rst_q)
    (rd_en && addr == ADDR_W'('h10A)) |=> (rdata == 8'h10));

  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_q)
    !rd_en |=> $stable(rdata));
endmodule

bind clkcfg_regbank clkcfg_regbank_chk #(.ADDR_W(ADDR_W), .KEY(KEY)) u_chk (
  .clk(clk), .rst_q(rst_q), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rd_en(rd_en), .rdata(rdata), .pll_mult(pll_mult), .pll_vdiv(pll_vdiv),
  .pll_en(pll_en), .bank_open(bank_open)
);

// File: tb/sim_clkcfg_regbank.sv
module sim_clkcfg_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic [3:0] pll_mult, vco_band, lpf_res, ss_interval, ss_dev;
  logic [1:0] pll_vdiv;
  logic       pll_en, ss_en;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic rd_q = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  clkcfg_regbank u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .pll_mult(pll_mult), .pll_vdiv(pll_vdiv),
    .pll_en(pll_en), .vco_band(vco_band), .lpf_res(lpf_res), .ss_en(ss_en),
    .ss_interval(ss_interval), .ss_dev(ss_dev)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // driver: one bus cycle, then the strobes are dropped again
  task automatic bus(input bit w, input bit r, input logic [8:0] a,
                     input logic [7:0] d, input logic [7:0] exp, input string tag);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    if (r) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input logic [8:0] a, input logic [7:0] d);
    bus(1'b1, 1'b0, a, d, 8'h00, "");
  endtask

  task automatic rd(input logic [8:0] a, input logic [7:0] exp, input string tag);
    bus(1'b0, 1'b1, a, 8'h00, exp, tag);
  endtask

  always @(posedge clk) rd_q <= rd_en;

  // monitor: compare each read result in the cycle after its strobe
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R12: read result 0x%0h with no expected item", rdata);
      end else begin
        string t;
        logic [7:0] e;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rdata, e, t);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, got 0 expected 1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(pll_mult, 0, "R1 mult");
    check(pll_vdiv, 1, "R1 vdiv");
    check(pll_en, 0, "R1 en");
    check(vco_band, 1, "R1 vco");
    check(lpf_res, 8, "R1 lpf");
    check(ss_en, 0, "R1 ss_en");
    check({ss_interval, ss_dev}, 0, "R1 ss cfg");
    rd(9'h110, 8'h00, "R1 key closed");
    rd(9'h108, 8'h04, "R1 ctl0");
    rd(9'h109, 8'h18, "R1 ctl1");
    // R4 locked writes dropped
    wr(9'h108, 8'hF5);
    check(pll_mult, 0, "R4 mult locked");
    check(pll_en, 0, "R4 en locked");
    wr(9'h10D, 8'hFF);
    rd(9'h10D, 8'h00, "R4 sscfg locked");
    // R2 unlock
    wr(9'h110, 8'h96);
    rd(9'h110, 8'h01, "R2 key open");
    // R5 ctl0 layout
    wr(9'h108, 8'h7B);
    check(pll_mult, 7, "R5 mult");
    check(pll_vdiv, 2, "R5 vdiv");
    check(pll_en, 1, "R5 en");
    rd(9'h108, 8'h79, "R5 bit1 reads 0");
    // R6 vdiv code 0 refused
    wr(9'h108, 8'h31);
    check(pll_vdiv, 2, "R6 vdiv kept");
    check(pll_mult, 3, "R6 mult taken");
    rd(9'h108, 8'h39, "R6 readback");
    // R7
    wr(9'h109, 8'hA5);
    check(vco_band, 4'hA, "R7 vco");
    check(lpf_res, 4'h5, "R7 lpf");
    // R8
    wr(9'h10A, 8'hFF);
    rd(9'h10A, 8'h10, "R8 status fixed");
    rd(9'h109, 8'hA5, "R8 neighbour untouched");
    // R9
    wr(9'h10C, 8'hFF);
    check(ss_en, 1, "R9 ss_en");
    rd(9'h10C, 8'h01, "R9 reserved zero");
    // R10
    wr(9'h10D, 8'h3C);
    check(ss_interval, 3, "R10 interval");
    check(ss_dev, 4'hC, "R10 dev");
    // R11 unmapped
    wr(9'h10B, 8'hFF);
    rd(9'h10B, 8'h00, "R11 unmapped 10B");
    rd(9'h100, 8'h00, "R11 unmapped 100");
    rd(9'h10E, 8'h00, "R11 unmapped 10E");
    rd(9'h10D, 8'h3C, "R11 no side effect");
    // R12 read and write in one cycle
    bus(1'b1, 1'b1, 9'h109, 8'h42, 8'hA5, "R12 old value on collision");
    rd(9'h109, 8'h42, "R12 new value after");
    @(negedge clk);
    check(rdata, 8'h42, "R12 hold");
    // R3 relock then guarded write immediately after
    bus(1'b1, 1'b0, 9'h110, 8'h95, 8'h00, "");
    @(negedge clk); wr_en = 1'b1; addr = 9'h108; wdata = 8'hFF;
    @(negedge clk); wr_en = 1'b0;
    check(pll_mult, 3, "R3 relock drops next write");
    rd(9'h110, 8'h00, "R3 key closed");
    rd(9'h109, 8'h42, "R11 read while closed");
    wr(9'h110, 8'h96);
    wr(9'h110, 8'h69);
    wr(9'h10C, 8'h00);
    check(ss_en, 1, "R3 relock by other byte");
    repeat (2) @(negedge clk);
    check(exp_q.size(), 0, "R12 all reads answered");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule